// File: doc/BRIEF.md
# PHY Register Access Control Register

This block is a single 32-bit control/status word on a host register bus. Software uses it to reach the internal registers of an attached PHY. The word holds a 4-bit target address and 8-bit write data. Setting one of two command bits launches a read or a write of that PHY register.

The command goes out on a request port using a valid/ready handshake. Back-pressure works as follows:
- Once `req_valid` rises, the request fields stay frozen until the PHY side raises `req_ready`.
- The transfer happens on the clock edge where both are high.
- The command bit that software set reads back as 1 for as long as the request is pending, and clears on that accepting edge.

Transfers that return from the PHY arrive on a response port as a single-cycle strobe. The response port has no ready; it is always taken. A response updates the captured address/data fields and sets a sticky done flag. That flag clears whenever software launches a new command.

Host reads are combinational: `host_rdata` reflects the word in the same cycle the offset is presented. Host writes take effect at the next clock edge, and only on enabled byte lanes.

Top module: `phy_reg_access_ctrl`

## Requirements
- R1: After reset the word reads 0000_0000h and `req_valid` is 0.
- R2: Bits 11:8 (target address, written on byte lane 1) and bits 7:0 (write data, lane 0) are read/write. Bits 31:16 cannot be changed by host writes. Reserved bits 30:28 and 13:12 always read 0.
- R3: A host write with lane 1 enabled and bit 15 = 1, while no request is pending, raises `req_valid` with `req_is_read`=1 and `req_addr` equal to the target address after that write. Bit 15 then reads 1. With lane 1 disabled, bit 15 launches nothing.
- R4: The same write with bit 14 = 1 (bit 15 = 0) issues a write: `req_is_read`=0, and `req_addr`/`req_data` equal the target address and write data after that write. Bit 14 then reads 1.
- R5: While `req_valid`=1 and `req_ready`=0, the request fields hold steady. On the edge where `req_ready`=1, the request is accepted: from the next cycle `req_valid`=0 and both command bits read 0.
- R6: A write setting bits 15 and 14 together is treated as a read. Bit 14 stays 0.
- R7: Command bits written while a request is pending are ignored, so the pending request's type, address and data do not change. The field writes of that same host write still apply.
- R8: A cycle with `rsp_valid`=1 stores `rsp_addr` into bits 27:24 and `rsp_data` into bits 23:16, and sets bit 31 (done).
- R9: Launching a command clears bit 31. If a response arrives in the same cycle, the clear wins, but the address/data capture still happens.
- R10: Host writes to any other offset are ignored. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_be | input | 4 | Host byte-lane enables |
| host_rdata | output | 32 | Read-back of the word (0 if offset misses) |
| req_valid | output | 1 | Request pending toward the PHY |
| req_ready | input | 1 | PHY side accepts the request |
| req_is_read | output | 1 | 1 = read request, 0 = write request |
| req_addr | output | 4 | PHY register address of the request |
| req_data | output | 8 | Data for a write request |
| rsp_valid | input | 1 | One-cycle strobe of a returned register transfer |
| rsp_addr | input | 4 | Address of the returned register |
| rsp_data | input | 8 | Contents of the returned register |

## Verification
The field sweep writes every target address with several data patterns, using full and partial byte enables and stray upper-byte bits. This separates lane gating from the read-only upper half. Commands are swept over all 16 addresses, both types and accept delays of 0 to 3 cycles. This separates the launch path, the hold-under-stall behaviour and the clearing edge. Separate cases cover a double-set command, a command during a pending request, and a command disabled by its lane. The response sweep walks all addresses with distinct data, and one pattern lands a response on the same edge as a command launch to show which update wins.

// File: rtl/phyacc_pkg.sv
package phyacc_pkg;
  localparam int PA_W = 4;
  localparam int PD_W = 8;

  localparam int B_DONE = 31;
  localparam int B_RD   = 15;
  localparam int B_WR   = 14;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  typedef struct packed {
    logic            is_read;
    logic [PA_W-1:0] addr;
    logic [PD_W-1:0] data;
  } phy_req_t;
endpackage

// File: rtl/phyacc_host_if.sv
module phyacc_host_if
  import phyacc_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter logic [HOST_AW-1:0] REG_OFFSET = 'hEC
) (
  input  logic               host_wr_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  input  logic [3:0]         host_be,
  input  logic [PA_W-1:0]    cur_addr,
  input  logic [PD_W-1:0]    cur_data,
  output logic               sel,
  output logic               we_addr,
  output logic               we_data,
  output logic [PA_W-1:0]    nxt_addr,
  output logic [PD_W-1:0]    nxt_data,
  output cmd_e               cmd
);
  logic wr_hit;

  always_comb begin
    sel      = (host_addr == REG_OFFSET);
    wr_hit   = sel && host_wr_en;
    we_data  = wr_hit && host_be[0];
    we_addr  = wr_hit && host_be[1];
    nxt_data = we_data ? host_wdata[PD_W-1:0] : cur_data;
    nxt_addr = we_addr ? host_wdata[8 +: PA_W] : cur_addr;
    // read bit wins over write bit when both are set
    if (!we_addr)                cmd = CMD_NONE;
    else if (host_wdata[B_RD])   cmd = CMD_READ;
    else if (host_wdata[B_WR])   cmd = CMD_WRITE;
    else                         cmd = CMD_NONE;
  end
endmodule

// File: rtl/phyacc_cmd.sv
module phyacc_cmd
  import phyacc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  cmd_e            cmd_in,
  input  logic [PA_W-1:0] nxt_addr,
  input  logic [PD_W-1:0] nxt_data,
  input  logic            req_ready,
  output logic            req_valid,
  output phy_req_t        req,
  output logic            issue,
  output logic            rd_busy,
  output logic            wr_busy
);
  logic     pend_q;
  phy_req_t req_q;

  assign issue     = (cmd_in != CMD_NONE) && !pend_q;
  assign req_valid = pend_q;
  assign req       = req_q;
  assign rd_busy   = pend_q && req_q.is_read;
  assign wr_busy   = pend_q && !req_q.is_read;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= '0;
    end else if (issue) begin
      pend_q        <= 1'b1;
      req_q.is_read <= (cmd_in == CMD_READ);
      req_q.addr    <= nxt_addr;
      req_q.data    <= nxt_data;
    end else if (pend_q && req_ready) begin
      pend_q <= 1'b0;
    end
  end

  a_r5_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req));
  a_r5_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);
  a_r7_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (cmd_in != CMD_NONE) |=> $stable(req));
  a_r6_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_busy, wr_busy}));
endmodule

// File: rtl/phyacc_capture.sv
module phyacc_capture
  import phyacc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rsp_valid,
  input  logic [PA_W-1:0] rsp_addr,
  input  logic [PD_W-1:0] rsp_data,
  input  logic            cmd_issue,
  output logic            done,
  output logic [PA_W-1:0] cap_addr,
  output logic [PD_W-1:0] cap_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      if (rsp_valid) begin
        cap_addr <= rsp_addr;
        cap_data <= rsp_data;
      end
      if (cmd_issue)      done <= 1'b0;
      else if (rsp_valid) done <= 1'b1;
    end
  end

  a_r8_done_on_reply: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !cmd_issue |=> done);
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |=> !done);
  a_r8_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> $stable(cap_addr) && $stable(cap_data));
endmodule

// File: rtl/phy_reg_access_ctrl.sv
module phy_reg_access_ctrl
  import phyacc_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter logic [HOST_AW-1:0] REG_OFFSET = 'hEC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  input  logic [3:0]         host_be,
  output logic [31:0]        host_rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_is_read,
  output logic [PA_W-1:0]    req_addr,
  output logic [PD_W-1:0]    req_data,
  input  logic               rsp_valid,
  input  logic [PA_W-1:0]    rsp_addr,
  input  logic [PD_W-1:0]    rsp_data
);
  logic [PA_W-1:0] fld_addr_q, nxt_addr, cap_addr;
  logic [PD_W-1:0] fld_data_q, nxt_data, cap_data;
  logic            sel, we_addr, we_data, issue, rd_busy, wr_busy, done;
  cmd_e            cmd;
  phy_req_t        req;

  phyacc_host_if #(.HOST_AW(HOST_AW), .REG_OFFSET(REG_OFFSET)) u_host (
    .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_be(host_be), .cur_addr(fld_addr_q), .cur_data(fld_data_q),
    .sel(sel), .we_addr(we_addr), .we_data(we_data),
    .nxt_addr(nxt_addr), .nxt_data(nxt_data), .cmd(cmd)
  );

  phyacc_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd), .nxt_addr(nxt_addr),
    .nxt_data(nxt_data), .req_ready(req_ready), .req_valid(req_valid),
    .req(req), .issue(issue), .rd_busy(rd_busy), .wr_busy(wr_busy)
  );

  phyacc_capture u_cap (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data), .cmd_issue(issue), .done(done),
    .cap_addr(cap_addr), .cap_data(cap_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld_addr_q <= '0;
      fld_data_q <= '0;
    end else begin
      if (we_addr) fld_addr_q <= nxt_addr;
      if (we_data) fld_data_q <= nxt_data;
    end
  end

  assign req_is_read = req.is_read;
  assign req_addr    = req.addr;
  assign req_data    = req.data;

  always_comb begin
    host_rdata = '0;
    if (sel) begin
      host_rdata[B_DONE]      = done;
      host_rdata[27:24]       = cap_addr;
      host_rdata[23:16]       = cap_data;
      host_rdata[B_RD]        = rd_busy;
      host_rdata[B_WR]        = wr_busy;
      host_rdata[11:8]        = fld_addr_q;
      host_rdata[7:0]         = fld_data_q;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !req_valid && !done);
  a_r5_busy_tracks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy || wr_busy) == req_valid);
endmodule

// File: tb/tb_phy_reg_access_ctrl.sv
module tb_phy_reg_access_ctrl;
  localparam logic [7:0] OFF = 8'hEC;

  logic        clk = 0, rst_n = 0;
  logic        host_wr_en = 0, req_ready = 0, rsp_valid = 0;
  logic [7:0]  host_addr = OFF;
  logic [31:0] host_wdata = 0;
  logic [3:0]  host_be = 0;
  logic [31:0] host_rdata;
  logic        req_valid, req_is_read;
  logic [3:0]  req_addr, rsp_addr = 0;
  logic [7:0]  req_data, rsp_data = 0;

  phy_reg_access_ctrl dut (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic       m_done = 0, m_rd = 0, m_wr = 0;
  logic [3:0] m_ca = 0, m_fa = 0;
  logic [7:0] m_cd = 0, m_fd = 0;

  function automatic logic [31:0] exp_word();
    return {m_done, 3'b000, m_ca, m_cd, m_rd, m_wr, 2'b00, m_fa, m_fd};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_word(input string tag);
    host_addr = OFF;
    #1 chk(tag, host_rdata, exp_word());
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    host_addr = a; host_wdata = d; host_be = be; host_wr_en = 1;
    @(negedge clk);
    host_wr_en = 0; host_be = 0; host_addr = OFF;
  endtask

  task automatic respond(input logic [3:0] a, input logic [7:0] d);
    rsp_valid = 1; rsp_addr = a; rsp_data = d;
    @(negedge clk);
    rsp_valid = 0;
    m_ca = a; m_cd = d; m_done = 1;
  endtask

  task automatic accept();
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    m_rd = 0; m_wr = 0;
    chk("R5 valid drops", {31'b0, req_valid}, 32'd0);
    check_word("R5 cmd bits clear");
  endtask

  task automatic do_cmd(input logic isrd, input logic [3:0] a, input logic [7:0] d, input int dly);
    host_wr(OFF, {16'hFFFF, isrd, ~isrd, 2'b11, a, d}, 4'b0011);
    m_fa = a; m_fd = d; m_done = 0; m_rd = isrd; m_wr = ~isrd;
    chk(isrd ? "R3 valid" : "R4 valid", {31'b0, req_valid}, 32'd1);
    chk(isrd ? "R3 type" : "R4 type", {31'b0, req_is_read}, {31'b0, isrd});
    chk(isrd ? "R3 addr" : "R4 addr", {28'b0, req_addr}, {28'b0, a});
    if (!isrd) chk("R4 data", {24'b0, req_data}, {24'b0, d});
    check_word("R9 launch clears done");
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R5 stall hold", {19'b0, req_valid, req_is_read, req_addr, isrd ? 8'h00 : req_data},
          {19'b0, 1'b1, isrd, a, isrd ? 8'h00 : d});
    end
    accept();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check_word("R1 reset word");
    chk("R1 reset valid", {31'b0, req_valid}, 32'd0);

    // R2 field sweep, upper bytes written with junk
    for (int a = 0; a < 16; a++) begin
      logic [7:0] d;
      d = 8'(a * 37 + 5);
      host_wr(OFF, {8'hFF, 8'hFF, 4'b0011, a[3:0], d}, 4'b1111);
      m_fa = a[3:0]; m_fd = d;
      check_word("R2 field write");
    end
    host_wr(OFF, 32'h0000_0A66, 4'b0001);
    m_fd = 8'h66;
    check_word("R2 lane0 only");
    host_wr(OFF, 32'h0000_0599, 4'b0010);
    m_fa = 4'h5;
    check_word("R2 lane1 only");

    // R10 other offsets
    host_wr(8'hE8, 32'h0000_8F11, 4'b1111);
    check_word("R10 miss write");
    chk("R10 miss no req", {31'b0, req_valid}, 32'd0);
    host_addr = 8'hF0;
    #1 chk("R10 miss read", host_rdata, 32'd0);

    // R3 lane 1 disabled: no launch
    host_wr(OFF, 32'h0000_8033, 4'b0001);
    m_fd = 8'h33;
    chk("R3 lane gate", {31'b0, req_valid}, 32'd0);
    check_word("R3 lane gate word");

    // R8 response sweep
    for (int a = 0; a < 16; a++) begin
      respond(a[3:0], 8'(a * 17) ^ 8'h5A);
      check_word("R8 capture");
    end

    // R3/R4/R5 command sweep
    for (int t = 0; t < 2; t++)
      for (int a = 0; a < 16; a++)
        do_cmd(t == 0, a[3:0], 8'(a * 11 + t), (a + t) % 4);

    // R6 both bits
    host_wr(OFF, 32'h0000_C7AA, 4'b0011);
    m_fa = 4'h7; m_fd = 8'hAA; m_rd = 1; m_wr = 0; m_done = 0;
    chk("R6 type read", {31'b0, req_is_read}, 32'd1);
    check_word("R6 bit14 low");
    accept();

    // R7 command while pending
    host_wr(OFF, 32'h0000_4312, 4'b0011);
    m_fa = 4'h3; m_fd = 8'h12; m_wr = 1;
    host_wr(OFF, 32'h0000_8955, 4'b0011);
    m_fa = 4'h9; m_fd = 8'h55;
    chk("R7 type kept", {31'b0, req_is_read}, 32'd0);
    chk("R7 addr kept", {28'b0, req_addr}, 32'h3);
    chk("R7 data kept", {24'b0, req_data}, 32'h12);
    check_word("R7 fields still written");
    accept();

    // R9 response coincident with launch
    respond(4'hE, 8'hC1);
    check_word("R8 done set");
    host_addr = OFF; host_wdata = 32'h0000_8244; host_be = 4'b0011; host_wr_en = 1;
    rsp_valid = 1; rsp_addr = 4'h7; rsp_data = 8'h3C;
    @(negedge clk);
    host_wr_en = 0; host_be = 0; rsp_valid = 0;
    m_fa = 4'h2; m_fd = 8'h44; m_rd = 1; m_done = 0; m_ca = 4'h7; m_cd = 8'h3C;
    check_word("R9 clear wins, capture kept");
    accept();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule